// File: doc/BRIEF.md
# Multi-Rate Search and Lock Controller

This block is the digital control core of a multi-rate serial reclocker. It picks a candidate line rate, presents the matching divider select to the oscillator, and measures the divided oscillator against the system clock. The divided oscillator arrives as a one-cycle enable pulse, `osc_tick`. The controller counts these pulses over a fixed window of reference cycles. It declares lock when the count is close to the expected value. It declares loss of lock when the count drifts further away, because leaving lock uses a wider band than entering it.

In auto mode the controller walks through the supported rates in a fixed order. It stays on each candidate for a set number of windows and stops on the first one that measures in band. It reports the rate it is locked to, or the rate it last locked to. In manual mode the candidate is the programmed rate and no search takes place. After a loss of lock the controller stays on the rate it had locked to, so a brief interruption can be recovered quickly.

A parameter chooses between the high-definition capable variant, which has six rates, and the standard-definition-only variant, which has five.

Top module: `rate_lock_ctrl`

## Requirements
- R1: After reset, `locked` is 0, `sd_flag` is 0, `div_sel` is 000 and `rate_code` is 000.
- R2: A measurement window is WIN_LEN clock cycles long. The first window starts on the first clock after reset is released. The measured count is the number of cycles in the window with `osc_tick` high. `locked` changes only on the clock edge that ends a window.
- R3: The rate codes are 000=143, 001=177, 010=270, 011=360, 100=540 and 101=1485 Mb/s. In auto mode, while unlocked, the candidate stays for DWELL windows. It then advances in the order 000, 001, 010, 011, 100, 101, and then wraps to 000. On the standard-definition variant, 100 wraps to 000.
- R4: When `asi_on` is high in auto mode, the search steps from 000 directly to 010. The controller never enters lock at 001.
- R5: While unlocked, the controller locks at the end of a window if |count − EXP_CNT| ≤ EXP_CNT·LOCK_PCT/100.
- R6: While locked, the controller unlocks at the end of a window if |count − EXP_CNT| > EXP_CNT·UNLOCK_PCT/100. Otherwise it stays locked.
- R7: After a loss of lock, the candidate (`div_sel`) stays at the rate that was locked. The search resumes from that rate.
- R8: In auto mode, `rate_code` shows the rate most recently locked to, or 000 before the first lock. In manual mode it shows the rate in use, which equals `div_sel`.
- R9: `sd_flag` is high only when the controller is locked to a rate other than 101.
- R10: In manual mode (`auto_en`=0), a valid `prog_rate` becomes the candidate at the end of a window. The candidate never advances on its own. A programmed rate that differs from the candidate while locked drops lock at that window end.
- R11: On the standard-definition variant, programmed codes above 100, including 101, are ignored and the previous candidate is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that defines the measurement window |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per divided oscillator period |
| auto_en | input | 1 | 1 = search for the rate automatically, 0 = use prog_rate |
| asi_on | input | 1 | Removes code 001 from the auto search |
| prog_rate | input | 3 | Programmed rate code used in manual mode |
| div_sel | output | 3 | Current candidate rate, selects the oscillator divider |
| rate_code | output | 3 | Reported rate code |
| locked | output | 1 | Frequency lock indication |
| sd_flag | output | 1 | High when locked to a standard-definition rate |

## Verification
The bench hits the lock band exactly at its edge, one count inside and one count outside. A design with an off-by-one tolerance would lock too early or refuse a valid rate. While locked, the bench applies an error that is too large to enter lock but small enough to hold it. A design without hysteresis would then drop lock. The bench also checks that the candidate stays put after loss of lock, that the search skips 177 in ASI mode, and that a programmed HD code is refused on the SD-only variant. A design that restarts the search from 143, falls into 001, or follows the 101 code would show the wrong `div_sel`. Random auto-mode trials pick a source rate and an in-band error at random, and expect lock at the right rate within the length of one full search.

// File: rtl/rl_pkg.sv
package rl_pkg;
   typedef logic [2:0] rate_t;

   localparam rate_t RC_143 = 3'd0;
   localparam rate_t RC_177 = 3'd1;
   localparam rate_t RC_270 = 3'd2;
   localparam rate_t RC_360 = 3'd3;
   localparam rate_t RC_540 = 3'd4;
   localparam rate_t RC_HD  = 3'd5;

   typedef enum logic {ST_ACQ, ST_TRK} lock_st_t;

   // Search order with optional 177 skip and optional HD stage
   function automatic rate_t next_rate(input rate_t r, input logic skip177, input logic hd);
      case (r)
         RC_143:  return skip177 ? RC_270 : RC_177;
         RC_177:  return RC_270;
         RC_270:  return RC_360;
         RC_360:  return RC_540;
         RC_540:  return hd ? RC_HD : RC_143;
         default: return RC_143;
      endcase
   endfunction
endpackage

// File: rtl/rl_freq_meter.sv
module rl_freq_meter #(
   parameter int WIN_LEN = 1024,
   parameter int CW      = 11
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   output logic          win_end,
   output logic [CW-1:0] total
);
   localparam int PW = $clog2(WIN_LEN);

   logic [PW-1:0] phase;
   logic [CW-1:0] acc;

   assign win_end = (phase == PW'(WIN_LEN - 1));
   assign total   = acc + CW'(tick);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= '0;
         acc   <= '0;
      end else if (win_end) begin
         phase <= '0;
         acc   <= '0;
      end else begin
         phase <= phase + 1'b1;
         acc   <= total;
      end
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      acc <= CW'(phase)); // R2
endmodule

// File: rtl/rl_band_judge.sv
module rl_band_judge #(
   parameter int CW         = 11,
   parameter int EXP_CNT    = 512,
   parameter int LOCK_PCT   = 1,
   parameter int UNLOCK_PCT = 2
) (
   input  logic [CW-1:0] total,
   output logic          near,
   output logic          far
);
   localparam int TOL_IN  = EXP_CNT * LOCK_PCT / 100;
   localparam int TOL_OUT = EXP_CNT * UNLOCK_PCT / 100;
   localparam logic [CW-1:0] EXP_V = CW'(EXP_CNT);

   logic [CW-1:0] diff;

   always_comb begin
      if (total > EXP_V) diff = total - EXP_V;
      else               diff = EXP_V - total;
   end

   assign near = (diff <= CW'(TOL_IN));
   assign far  = (diff >  CW'(TOL_OUT));
endmodule

// File: rtl/rl_search_fsm.sv
module rl_search_fsm
   import rl_pkg::*;
#(
   parameter int DWELL = 2,
   parameter bit HD_EN = 1'b1
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  win_end,
   input  logic  near,
   input  logic  far,
   input  logic  auto_en,
   input  logic  asi_on,
   input  rate_t prog_rate,
   output rate_t cand,
   output rate_t rate_code,
   output logic  locked,
   output logic  sd_flag
);
   localparam int DW = (DWELL > 1) ? $clog2(DWELL) : 1;

   lock_st_t      st;
   rate_t         last_rate;
   logic [DW-1:0] dwell;
   rate_t         top_code;
   rate_t         eff_prog;
   logic          blocked;
   logic          retarget;

   generate
      if (HD_EN) begin : g_hd
         assign top_code = RC_HD;
      end else begin : g_sd
         assign top_code = RC_540;
      end
   endgenerate

   assign eff_prog  = (prog_rate <= top_code) ? prog_rate : cand;
   assign retarget  = !auto_en && (eff_prog != cand);
   assign blocked   = auto_en && asi_on && (cand == RC_177);
   assign locked    = (st == ST_TRK);
   assign sd_flag   = locked && (cand != RC_HD);
   assign rate_code = auto_en ? last_rate : cand;

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= ST_ACQ;
         cand      <= RC_143;
         last_rate <= RC_143;
         dwell     <= '0;
      end else if (win_end) begin
         if (st == ST_TRK) begin
            if (far || retarget) begin
               st    <= ST_ACQ;
               dwell <= '0;
               if (retarget) cand <= eff_prog;
            end
         end else if (retarget) begin
            cand  <= eff_prog;
            dwell <= '0;
         end else if (near && !blocked) begin
            st        <= ST_TRK;
            last_rate <= cand;
            dwell     <= '0;
         end else if (auto_en) begin
            if (dwell == DW'(DWELL - 1)) begin
               dwell <= '0;
               cand  <= next_rate(cand, asi_on, HD_EN);
            end else begin
               dwell <= dwell + 1'b1;
            end
         end
      end
   end

   AST_LOCK_AT_WINDOW: assert property (@(posedge clk) disable iff (rst)
      (st != $past(st)) |-> $past(win_end)); // R2
   AST_CAND_RANGE: assert property (@(posedge clk) disable iff (rst)
      cand <= top_code); // R3
   AST_DWELL_BOUND: assert property (@(posedge clk) disable iff (rst)
      32'(dwell) < DWELL); // R3
   AST_NO_ASI_177: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> !($past(auto_en) && $past(asi_on) && cand == RC_177)); // R4
   AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $fell(locked) |-> ($past(far) || !$past(auto_en))); // R6
   AST_HOLD_WHILE_LOCKED: assert property (@(posedge clk) disable iff (rst)
      (locked && $past(locked) && $past(auto_en)) |-> $stable(cand)); // R7
endmodule

// File: rtl/rate_lock_ctrl.sv
module rate_lock_ctrl #(
   parameter int WIN_LEN    = 1024,
   parameter int EXP_CNT    = 512,
   parameter int LOCK_PCT   = 1,
   parameter int UNLOCK_PCT = 2,
   parameter int DWELL      = 2,
   parameter bit HD_EN      = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       osc_tick,
   input  logic       auto_en,
   input  logic       asi_on,
   input  logic [2:0] prog_rate,
   output logic [2:0] div_sel,
   output logic [2:0] rate_code,
   output logic       locked,
   output logic       sd_flag
);
   localparam int CW = $clog2(WIN_LEN + 1);

   generate
      if (WIN_LEN < 2) begin : g_bad_win
         $error("WIN_LEN must be at least 2");
      end
      if (EXP_CNT < 1 || EXP_CNT > WIN_LEN) begin : g_bad_exp
         $error("EXP_CNT must lie in 1..WIN_LEN");
      end
      if (UNLOCK_PCT < LOCK_PCT) begin : g_bad_band
         $error("UNLOCK_PCT must not be below LOCK_PCT");
      end
      if (DWELL < 1) begin : g_bad_dwell
         $error("DWELL must be at least 1");
      end
   endgenerate

   logic          win_end;
   logic [CW-1:0] total;
   logic          near;
   logic          far;

   rl_freq_meter #(.WIN_LEN(WIN_LEN), .CW(CW)) u_meter (
      .clk(clk), .rst(rst), .tick(osc_tick), .win_end(win_end), .total(total)
   );

   rl_band_judge #(.CW(CW), .EXP_CNT(EXP_CNT), .LOCK_PCT(LOCK_PCT),
                   .UNLOCK_PCT(UNLOCK_PCT)) u_judge (
      .total(total), .near(near), .far(far)
   );

   rl_search_fsm #(.DWELL(DWELL), .HD_EN(HD_EN)) u_fsm (
      .clk(clk), .rst(rst), .win_end(win_end), .near(near), .far(far),
      .auto_en(auto_en), .asi_on(asi_on), .prog_rate(prog_rate),
      .cand(div_sel), .rate_code(rate_code), .locked(locked), .sd_flag(sd_flag)
   );
endmodule

// File: tb/sim_rate_lock_ctrl.sv
module sim_rate_lock_ctrl;
   localparam int WIN = 256;
   localparam int EXP = 200;
   localparam int FAR = 150;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick = 1'b0;
   logic       auto_en = 1'b1;
   logic       asi_on = 1'b0;
   logic [2:0] prog_rate = 3'd0;
   logic [2:0] div_sel, rate_code, div_sel1, rate_code1;
   logic       locked, sd_flag, locked1, sd_flag1;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   rate_lock_ctrl #(.WIN_LEN(WIN), .EXP_CNT(EXP), .LOCK_PCT(1), .UNLOCK_PCT(2),
                    .DWELL(2), .HD_EN(1'b1)) u0 (
      .clk(clk), .rst(rst), .osc_tick(tick), .auto_en(auto_en), .asi_on(asi_on),
      .prog_rate(prog_rate), .div_sel(div_sel), .rate_code(rate_code),
      .locked(locked), .sd_flag(sd_flag));

   rate_lock_ctrl #(.WIN_LEN(WIN), .EXP_CNT(EXP), .LOCK_PCT(1), .UNLOCK_PCT(2),
                    .DWELL(2), .HD_EN(1'b0)) u1 (
      .clk(clk), .rst(rst), .osc_tick(tick), .auto_en(auto_en), .asi_on(asi_on),
      .prog_rate(prog_rate), .div_sel(div_sel1), .rate_code(rate_code1),
      .locked(locked1), .sd_flag(sd_flag1));

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One window; the source matches only when the candidate equals src
   task automatic win(input int src, input int err);
      int k;
      k = (int'(div_sel) == src) ? EXP + err : FAR;
      for (int i = 0; i < WIN; i++) begin
         tick = (i < k);
         @(negedge clk);
      end
      tick = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      tick = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wait_lock(input int src, input int err, input int limit);
      for (int w = 0; w < limit; w++) begin
         if (locked) break;
         win(src, err);
      end
   endtask

   function automatic int sd_expect(input int r);
      return (r != 5) ? 1 : 0;
   endfunction

   initial begin
      int order[7] = '{0, 1, 2, 3, 4, 5, 0};
      int seed_dummy;
      seed_dummy = $urandom(32'd4242);

      repeat (3) @(negedge clk);
      chk("R1 locked at reset", int'(locked), 0);
      chk("R1 sd_flag at reset", int'(sd_flag), 0);
      chk("R1 div_sel at reset", int'(div_sel), 0);
      chk("R1 rate_code at reset", int'(rate_code), 0);
      rst = 1'b0;

      // R3: search order with two windows per candidate, no source present
      for (int w = 1; w <= 12; w++) begin
         win(7, 0);
         chk($sformatf("R3 search step window %0d", w), int'(div_sel), order[w / 2]);
      end
      chk("R2 no lock without source", int'(locked), 0);

      // R4: ASI skips 177
      asi_on = 1'b1;
      win(7, 0);
      chk("R4 dwell before skip", int'(div_sel), 0);
      win(7, 0);
      chk("R4 skip 001", int'(div_sel), 2);
      for (int w = 0; w < 14; w++) begin
         win(1, 0);
         chk("R4 no lock at 001 in ASI mode", int'(locked), 0);
         chk("R4 candidate never 001", int'(div_sel == 3'd1), 0);
      end
      asi_on = 1'b0;

      // R5/R8/R9: lock at 360
      wait_lock(3, 0, 16);
      chk("R5 lock at 360", int'(locked), 1);
      chk("R8 rate_code locked 360", int'(rate_code), 3);
      chk("R9 sd_flag at 360", int'(sd_flag), 1);

      // R6: hysteresis while tracking
      win(3, 4);
      chk("R6 stays locked at +2%", int'(locked), 1);
      win(3, -4);
      chk("R6 stays locked at -2%", int'(locked), 1);
      win(3, 5);
      chk("R6 unlock beyond 2%", int'(locked), 0);
      chk("R9 sd_flag low unlocked", int'(sd_flag), 0);
      chk("R7 candidate held after unlock", int'(div_sel), 3);
      chk("R8 rate_code keeps last lock", int'(rate_code), 3);

      // R5: lock band edge
      win(3, 3);
      chk("R5 no lock just outside 1%", int'(locked), 0);
      win(3, -2);
      chk("R5 lock at 1% edge", int'(locked), 1);

      // R9: HD rate
      wait_lock(5, 0, 2);
      win(5, 0);
      wait_lock(5, 0, 16);
      chk("R3 lock found at 101", int'(locked), 1);
      chk("R8 rate_code 101", int'(rate_code), 5);
      chk("R9 sd_flag low at 101", int'(sd_flag), 0);

      // R10: manual mode
      auto_en = 1'b0;
      prog_rate = 3'd4;
      win(4, 0);
      chk("R10 retarget drops lock", int'(locked), 0);
      chk("R10 candidate is programmed rate", int'(div_sel), 4);
      wait_lock(4, 0, 4);
      chk("R10 lock at programmed 540", int'(locked), 1);
      chk("R8 manual rate_code", int'(rate_code), 4);
      for (int w = 0; w < 5; w++) win(7, 0);
      chk("R10 unlocked without source", int'(locked), 0);
      chk("R10 no advance in manual", int'(div_sel), 4);
      wait_lock(4, 0, 4);
      chk("R10 relock in manual", int'(locked), 1);
      prog_rate = 3'd2;
      win(4, 0);
      chk("R10 program change drops lock", int'(locked), 0);
      chk("R10 new program taken", int'(div_sel), 2);
      chk("R10 SD variant takes 010", int'(div_sel1), 2);
      prog_rate = 3'd5;
      win(7, 0);
      chk("R10 HD variant takes 101", int'(div_sel), 5);
      chk("R11 SD variant ignores 101", int'(div_sel1), 2);
      win(7, 0);
      chk("R11 SD variant still ignores 101", int'(div_sel1), 2);

      // Random auto trials
      auto_en = 1'b1;
      for (int t = 0; t < 8; t++) begin
         int src;
         int err;
         src = int'($urandom_range(0, 5));
         asi_on = (src != 1) ? 1'($urandom_range(0, 1)) : 1'b0;
         err = int'($urandom_range(0, 4)) - 2;
         do_reset();
         wait_lock(src, err, 16);
         chk($sformatf("R5 random lock src %0d", src), int'(locked), 1);
         chk($sformatf("R8 random rate_code src %0d", src), int'(rate_code), src);
         chk($sformatf("R9 random sd_flag src %0d", src), int'(sd_flag), sd_expect(src));
         for (int w = 0; w < 2; w++) begin
            win(src, int'($urandom_range(0, 8)) - 4);
            chk($sformatf("R6 random hold src %0d", src), int'(locked), 1);
         end
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule